// File: doc/BRIEF.md
# Satellite LNB Tone and Command Transmitter

This block drives the control line of a satellite low-noise block converter from the system clock. It generates a square-wave tone whose period is a programmable multiple of 32 clocks and gates that tone in one of four ways. It can leave the tone running, keep it silent, send a mini-command burst that selects satellite A or B, or send a command message of one to eight bytes. Message bits are pulse-width coded and each byte carries an odd parity bit. A separate output bit picks the 13 V or 18 V supply level.

Software programs the block through a simple write port. It writes the divider, the control word (mode, satellite select, message length, go), the voltage bit and the message bytes. A busy output stays high from the accepted go until the last tone unit of the transfer ends. All timing is counted in whole tone periods. A "unit" is `UNIT_TONES` tone periods, which is 11 by default and gives 0.5 ms at 22 kHz.

Top module: `lnb_tx`

Write map: address 0 holds the divider D. Address 1 holds the control word, with bits [1:0] for the mode, bit 2 for the satellite select, bits [6:4] for the length field L and bit 7 for go. Address 2 holds the voltage bit in bit 0. Addresses 8+i hold message byte i.

## Requirements
- R1: The tone is a square wave with a period of max(D,1)×32 clocks and 50 % duty: high while the period counter is in its first half. In mode 0 (continuous) the tone is driven on `tone_out` without gaps.
- R2: Mode 3 (reserved) keeps `tone_out` at 0, and a go written with mode 3 (or mode 0) does not start a transfer.
- R3: Mode 2 (message) with length field L sends L+1 bytes, starting at byte 0. Each byte goes out MSB first and is followed by a parity bit that makes the count of ones in the nine bits odd.
- R4: A 0 bit is 2 units of tone then 1 unit of silence. A 1 bit is 1 unit of tone then 2 units of silence. One unit is `UNIT_TONES` tone periods.
- R5: Mode 1 (burst) with satellite select 0 sends one block of 25 units of unbroken tone.
- R6: Mode 1 with satellite select 1 sends nine pulses, each made of 1 unit of tone followed by 2 units of silence.
- R7: `busy` rises one cycle after the go write and falls after exactly the transfer's unit count × unit length clocks: 27 units per byte, 25 for burst A and 27 for burst B.
- R8: While a transfer is pending or running, writes to the divider, the control word and the message bytes are ignored. Voltage writes still take effect.
- R9: `volt_sel` equals bit 0 of the last voltage write (0 = 13 V, 1 = 18 V) from the cycle after the write, and changes at no other time.
- R10: After reset the mode is 3, the divider is 0, `volt_sel` is 0, `busy` is 0 and `tone_out` is 0.
- R11: In modes 1 and 2 the tone is silent while no transfer runs. A transfer starts at the top of a fresh tone period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| tone_out | output | 1 | Gated tone to the LNB line driver |
| volt_sel | output | 1 | Supply select, 0 = 13 V, 1 = 18 V |
| busy | output | 1 | High while a transfer is pending or in progress |

## Verification
The bench decodes `tone_out` into tone bursts and measures how many tone periods each burst holds and how long `busy` stays high. A design that swapped the bit shapes, sent LSB first or used even parity would yield a wrong burst sequence. One that dropped or added a byte at the length boundary, or miscounted units, would change the burst count or the busy time. Several cases cover the rules that are easy to get wrong. The divider is checked at 0 and at 2, where a wrong period would show up in the high and low widths. A go in the reserved mode must not start a transfer. A design that let message, divider or control writes through mid-transfer would corrupt the running pattern or the pattern that is replayed afterwards. The voltage write must still land during a transfer.

// File: rtl/lnb_pkg.sv
package lnb_pkg;
  parameter int DATA_W = 8;
  parameter int DIV_W  = 8;

  typedef enum logic [1:0] {
    MODE_CONT  = 2'd0,
    MODE_BURST = 2'd1,
    MODE_MSG   = 2'd2,
    MODE_OFF   = 2'd3
  } lnb_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ON   = 2'd1,
    SEQ_OFF  = 2'd2
  } seq_state_e;

  localparam int A_DIV    = 0;
  localparam int A_CTRL   = 1;
  localparam int A_VOLT   = 2;
  localparam int MSG_BASE = 8;

  localparam int BURST_A_UNITS = 25;
  localparam int PARITY_IDX    = 8;
endpackage

// File: rtl/lnb_regs.sv
module lnb_regs
  import lnb_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int ADDR_W = 4,
  localparam int LEN_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         busy,
  output logic [DIV_W-1:0]             div_q,
  output lnb_mode_e                    mode_q,
  output logic                         sat_b_q,
  output logic [LEN_W-1:0]             len_q,
  output logic                         volt_q,
  output logic [NBYTES-1:0][DATA_W-1:0] msg_q,
  output logic                         start_q
);
  logic lock, div_we, ctrl_we, volt_we, start_d;
  lnb_mode_e wr_mode;

  assign lock    = busy | start_q;
  assign wr_mode = lnb_mode_e'(wr_data[1:0]);
  assign div_we  = wr_en && !lock && (wr_addr == ADDR_W'(A_DIV));
  assign ctrl_we = wr_en && !lock && (wr_addr == ADDR_W'(A_CTRL));
  assign volt_we = wr_en && (wr_addr == ADDR_W'(A_VOLT));
  assign start_d = ctrl_we && wr_data[7] &&
                   ((wr_mode == MODE_BURST) || (wr_mode == MODE_MSG));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      mode_q  <= MODE_OFF;
      sat_b_q <= 1'b0;
      len_q   <= '0;
      volt_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= start_d;
      if (div_we) div_q <= wr_data[DIV_W-1:0];
      if (ctrl_we) begin
        mode_q  <= wr_mode;
        sat_b_q <= wr_data[2];
        len_q   <= wr_data[4 +: LEN_W];
      end
      if (volt_we) volt_q <= wr_data[0];
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_msg
    logic byte_we;
    assign byte_we = wr_en && !lock && (wr_addr == ADDR_W'(MSG_BASE + i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       msg_q[i] <= '0;
      else if (byte_we) msg_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/lnb_tone_div.sv
module lnb_tone_div
  import lnb_pkg::*;
#(
  parameter int UNIT_TONES = 11,
  localparam int CNT_W  = DIV_W + 5,
  localparam int UNIT_W = (UNIT_TONES > 1) ? $clog2(UNIT_TONES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             sq,
  output logic             unit_tick
);
  logic [DIV_W-1:0]  eff;
  logic [CNT_W-1:0]  cnt_q, cnt_d, period_last, half;
  logic [UNIT_W-1:0] ucnt_q, ucnt_d;
  logic              tone_tick, ucnt_en;

  assign eff         = (div == '0) ? DIV_W'(1) : div;
  assign period_last = {eff, 5'b0} - CNT_W'(1);
  assign half        = {1'b0, eff, 4'b0};
  assign tone_tick   = (cnt_q >= period_last);
  assign sq          = (cnt_q < half);
  assign unit_tick   = tone_tick && !clr && (ucnt_q == UNIT_W'(UNIT_TONES - 1));
  assign ucnt_en     = clr | tone_tick;

  always_comb begin
    cnt_d  = clr ? '0 : (tone_tick ? '0 : cnt_q + CNT_W'(1));
    ucnt_d = (clr || (ucnt_q == UNIT_W'(UNIT_TONES - 1))) ? '0 : ucnt_q + UNIT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ucnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (ucnt_en) ucnt_q <= ucnt_d;
    end
  end
endmodule

// File: rtl/lnb_seq.sv
module lnb_seq
  import lnb_pkg::*;
#(
  parameter int NBYTES = 8,
  localparam int LEN_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          unit_tick,
  input  lnb_mode_e                     mode,
  input  logic                          sat_b,
  input  logic [LEN_W-1:0]              len,
  input  logic [NBYTES-1:0][DATA_W-1:0] msg,
  output logic                          busy,
  output logic                          gate
);
  seq_state_e       state_q, state_d;
  logic [4:0]       left_q, left_d;
  logic [3:0]       bit_q, bit_d, nbit;
  logic [LEN_W-1:0] byte_q, byte_d, nbyte;
  logic             is_a, is_b, bit_now, bit_next, last, en;

  function automatic logic sym_bit(input logic [DATA_W-1:0] b, input logic [3:0] idx);
    logic [3:0] sh;
    sh = 4'd7 - idx;
    return (idx == 4'(PARITY_IDX)) ? ~^b : b[sh[2:0]];
  endfunction

  assign is_a     = (mode == MODE_BURST) && !sat_b;
  assign is_b     = (mode == MODE_BURST) && sat_b;
  assign nbit     = (bit_q == 4'(PARITY_IDX)) ? 4'd0 : bit_q + 4'd1;
  assign nbyte    = (bit_q == 4'(PARITY_IDX)) ? byte_q + LEN_W'(1) : byte_q;
  assign bit_now  = is_b | sym_bit(msg[byte_q], bit_q);
  assign bit_next = is_b | sym_bit(msg[nbyte], nbit);
  assign last     = (bit_q == 4'(PARITY_IDX)) && (is_b || (byte_q == len));
  assign en       = start | unit_tick;
  assign busy     = (state_q != SEQ_IDLE);
  assign gate     = (state_q == SEQ_ON);

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    unique case (state_q)
      SEQ_IDLE: if (start) begin
        state_d = SEQ_ON;
        left_d  = is_a ? 5'(BURST_A_UNITS) : (bit_now ? 5'd1 : 5'd2);
      end
      SEQ_ON: if (unit_tick) begin
        if (left_q != 5'd1)  left_d = left_q - 5'd1;
        else if (is_a) begin
          state_d = SEQ_IDLE;
          bit_d   = '0;
          byte_d  = '0;
        end else begin
          state_d = SEQ_OFF;
          left_d  = bit_now ? 5'd2 : 5'd1;
        end
      end
      SEQ_OFF: if (unit_tick) begin
        if (left_q != 5'd1) left_d = left_q - 5'd1;
        else if (last) begin
          state_d = SEQ_IDLE;
          bit_d   = '0;
          byte_d  = '0;
        end else begin
          state_d = SEQ_ON;
          bit_d   = nbit;
          byte_d  = nbyte;
          left_d  = bit_next ? 5'd1 : 5'd2;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
    end else if (en) begin
      state_q <= state_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
    end
  end
endmodule

// File: rtl/lnb_tx.sv
module lnb_tx
  import lnb_pkg::*;
#(
  parameter int NBYTES     = 8,
  parameter int UNIT_TONES = 11,
  parameter int ADDR_W     = 4,
  localparam int LEN_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              tone_out,
  output logic              volt_sel,
  output logic              busy
);
  logic [1:0]                    rst_sync;
  logic                          rst_i_n;
  logic [DIV_W-1:0]              div_q;
  lnb_mode_e                     mode_q;
  logic                          sat_b_q, volt_q, start_q, sq, unit_tick, gate;
  logic [LEN_W-1:0]              len_q;
  logic [NBYTES-1:0][DATA_W-1:0] msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  lnb_regs #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .div_q(div_q), .mode_q(mode_q),
    .sat_b_q(sat_b_q), .len_q(len_q), .volt_q(volt_q), .msg_q(msg_q),
    .start_q(start_q)
  );

  lnb_tone_div #(.UNIT_TONES(UNIT_TONES)) u_div (
    .clk(clk), .rst_n(rst_i_n), .clr(start_q), .div(div_q),
    .sq(sq), .unit_tick(unit_tick)
  );

  lnb_seq #(.NBYTES(NBYTES)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start_q), .unit_tick(unit_tick),
    .mode(mode_q), .sat_b(sat_b_q), .len(len_q), .msg(msg_q),
    .busy(busy), .gate(gate)
  );

  assign tone_out = sq & (gate | (mode_q == MODE_CONT));
  assign volt_sel = volt_q;
endmodule

// File: rtl/lnb_tx_chk.sv
module lnb_tx_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              tone_out,
  input logic              volt_sel,
  input logic              busy,
  input logic [1:0]        mode
);
  a_r2_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!tone_out && !busy));

  a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd1 || mode == 2'd2) && !busy) |-> !tone_out);

  a_r1_cont_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> !busy);

  a_r7_busy_from_go: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_addr == ADDR_W'(1) && wr_data[7], 2));

  a_r9_volt_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(2)) |=> (volt_sel == $past(wr_data[0])));

  a_r9_volt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(2)) |=> $stable(volt_sel));
endmodule

bind lnb_tx lnb_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .tone_out(tone_out), .volt_sel(volt_sel),
  .busy(busy), .mode(mode_q)
);

// File: tb/tb_lnb_tx.sv
`timescale 1ns/1ps
module tb_lnb_tx;
  localparam int UT = 2;
  localparam int UNIT_CLKS = UT * 32;
  localparam logic [21:0] VEC [0:5] = '{
    {2'd2, 1'b0, 3'd0, 8'hA5, 8'h00},
    {2'd2, 1'b0, 3'd1, 8'h01, 8'hFF},
    {2'd1, 1'b0, 3'd0, 8'h00, 8'h00},
    {2'd1, 1'b1, 3'd0, 8'h00, 8'h00},
    {2'd2, 1'b0, 3'd1, 8'h00, 8'h80},
    {2'd2, 1'b0, 3'd0, 8'h7E, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tone_out, volt_sel, busy;
  int checks = 0, errors = 0;
  int got [0:127];
  int expb [0:127];
  int got_n, exp_n, exp_units, dur;

  always #2.5 clk = ~clk;

  lnb_tx #(.UNIT_TONES(UT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tone_out(tone_out), .volt_sel(volt_sel), .busy(busy)
  );

  initial begin
    #900000;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors + 1);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Decode tone_out into bursts of tone periods; optionally disturb mid-run.
  task automatic capture(input bit disturb);
    int cnt = 0, gap = 0, cyc = 0;
    logic prev = 1'b0;
    got_n = 0; dur = 0;
    while (!( !busy && cnt == 0 && gap >= 48) && cyc < 100000) begin
      if (busy) dur++;
      if (tone_out && !prev) begin cnt++; gap = 0; end
      else gap++;
      if (gap == 48 && cnt > 0) begin got[got_n] = cnt; got_n++; cnt = 0; end
      prev = tone_out;
      if (disturb) begin
        case (cyc)
          20: begin wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h00; end
          21: begin wr_addr = 4'd1; wr_data = 8'h81; end
          22: begin wr_addr = 4'd0; wr_data = 8'h05; end
          23: begin wr_addr = 4'd2; wr_data = 8'h01; end
          24: wr_en = 1'b0;
          default: ;
        endcase
      end
      cyc++;
      @(negedge clk);
    end
    check("R7 capture finished", int'(cyc < 100000), 1);
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin expb[exp_n] = b[i] ? UT : 2 * UT; exp_n++; end
    expb[exp_n] = (~^b) ? UT : 2 * UT; exp_n++;
    exp_units += 27;
  endtask

  task automatic compare(input string tag);
    int bad = -1;
    check({tag, " R3 burst count"}, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      if (bad < 0 && got[k] != expb[k]) bad = k;
    check({tag, " R4 burst pulses"}, (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : expb[bad]);
    check({tag, " R7 busy clocks"}, dur, exp_units * UNIT_CLKS);
  endtask

  task automatic measure_cont(input int exp_half, input string tag);
    int hi = 0, lo = 0, w = 0;
    repeat (300) @(negedge clk);
    while (tone_out && w < 2000) begin w++; @(negedge clk); end
    while (!tone_out && w < 2000) begin w++; @(negedge clk); end
    while (tone_out && w < 4000) begin hi++; w++; @(negedge clk); end
    while (!tone_out && w < 6000) begin lo++; w++; @(negedge clk); end
    check({tag, " R1 high clocks"}, hi, exp_half);
    check({tag, " R1 low clocks"}, lo, exp_half);
  endtask

  initial begin
    logic [21:0] v;
    int tone_seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 tone_out after reset", tone_out, 0);
    check("R10 busy after reset", busy, 0);
    check("R10 volt_sel after reset", volt_sel, 0);
    tone_seen = 0;
    repeat (200) begin @(negedge clk); tone_seen |= tone_out; end
    check("R10 reset mode silent", tone_seen, 0);

    // Table walk: R3 R4 R5 R6 R7
    wr(0, 1);
    for (int t = 0; t < 6; t++) begin
      v = VEC[t];
      wr(8, v[15:8]);
      wr(9, v[7:0]);
      wr(1, {v[21:20]} | (v[19] << 2) | (v[18:16] << 4) | 8'h80);
      check("R7 busy not yet on go edge", busy, 0);
      exp_n = 0; exp_units = 0;
      if (v[21:20] == 2'd2) begin
        push_byte(v[15:8]);
        if (v[18:16] >= 3'd1) push_byte(v[7:0]);
      end else if (!v[19]) begin
        expb[0] = 25 * UT; exp_n = 1; exp_units = 25;   // R5
      end else begin
        for (int p = 0; p < 9; p++) expb[p] = UT;       // R6
        exp_n = 9; exp_units = 27;
      end
      capture(1'b0);
      compare($sformatf("vec%0d", t));
      check("R11 silent after transfer", tone_out, 0);
    end

    // R1 continuous tone, divider 2 and divider 0
    wr(0, 2); wr(1, 8'h00);
    measure_cont(32, "div2");
    wr(0, 0);
    measure_cont(16, "div0");

    // R2 reserved mode with go: no transfer, no tone
    wr(1, 8'h83);
    repeat (3) @(negedge clk);
    check("R2 go in mode 3 not busy", busy, 0);
    tone_seen = 0;
    repeat (300) begin @(negedge clk); tone_seen |= tone_out; end
    check("R2 mode 3 silent", tone_seen, 0);
    wr(1, 8'h80);
    repeat (3) @(negedge clk);
    check("R2 go in mode 0 not busy", busy, 0);

    // R8 locked writes during a transfer, voltage still accepted
    wr(1, 8'h03); wr(0, 1); wr(8, 8'hA5); wr(1, 8'h82);
    exp_n = 0; exp_units = 0; push_byte(8'hA5);
    capture(1'b1);
    compare("R8 locked");
    check("R8 volt write during busy", volt_sel, 1);
    // Replay without rewriting the message: byte, divider, control kept
    wr(1, 8'h82);
    capture(1'b0);
    compare("R8 replay");

    // R9 voltage back to 13 V
    wr(2, 0);
    check("R9 volt_sel 13V", volt_sel, 0);
    wr(2, 1);
    check("R9 volt_sel 18V", volt_sel, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule